// File: doc/BRIEF.md
# Arithmetic Condition and Skip/Jump Decision Unit

This unit makes the branch decision for the families of instructions that test a signed 36-bit two's-complement word against a 3-bit condition. These families are signed compare, memory test, increment-or-decrement-then-skip, increment-or-decrement-then-jump, and the paired half-word increment-then-jump. For each accepted operation the unit forms the result word. Where the instruction calls for it, this is the +1 or -1 of the accumulator or of the memory operand. The unit also decides whether the program skips or jumps, raises the write enables for the accumulator and the memory word, and reports the adder's carry and overflow flags.

A single 3-bit condition code serves every family, always with the same meaning. The code is evaluated on the signed value after any increment or decrement. For the compare family it is evaluated on the relation between the accumulator and the operand. Forms that modify memory write the accumulator only when the instruction's accumulator field is nonzero. The unit has one register stage: an operation presented with `in_valid` in one cycle appears on the outputs, qualified by `out_valid`, in the next. Memory sequencing is handled elsewhere.

Top module: `cs_cond_unit`

## Requirements
- R1: An operation accepted with `in_valid` high at a rising edge appears on the outputs, with `out_valid` high, after exactly that one edge. While reset (`rst_n` low) is applied, every output is zero.
- R2: Condition codes are: 0 never, 1 less than zero, 2 equal to zero, 3 less or equal, 4 always, 5 greater or equal, 6 nonzero, 7 greater than zero. The comparisons are signed, and the same meanings hold for every class. Code 0 never yields `take`. Code 4 always yields `take` for classes 0 to 6.
- R3: Class 0 (compare) yields `take` when the signed relation of `ac_val` to `operand` meets the code. It writes nothing, updates no flags and returns `ac_val` as `result`.
- R4: Class 1 (memory test) returns `operand` as `result` and applies the code to it. It raises `wr_ac` only when `ac_sel` is nonzero, never raises `wr_mem`, and updates no flags.
- R5: Classes 2 (increment) and 3 (decrement) return `operand`+1 or `operand`-1. They raise `wr_mem` and `flag_upd`, raise `wr_ac` only when `ac_sel` is nonzero, and apply the code to the new value.
- R6: Classes 4 (increment) and 5 (decrement) return `ac_val`+1 or `ac_val`-1. They raise `wr_ac` and `flag_upd`, never raise `wr_mem`, and apply the code to the new value.
- R7: Class 6 adds 1 to each 18-bit half of `ac_val` separately, with no carry passing from the right half into the left half. It raises `wr_ac`, never raises `flag_upd`, and applies the code to the result. Code 5 jumps when the result is nonnegative and code 1 when it is negative.
- R8: When `flag_upd` is high, `carry0` is the carry out of the most significant bit of the 36-bit adder and `carry1` is the carry into that bit. `ovf` is high exactly when the signed result wraps: incrementing 36'h7FFFFFFFF or decrementing 36'h800000000. When `flag_upd` is low, all three flags are zero.
- R9: Class 7 is reserved. It yields no write, no `take` and no flag update, and its `result` is zero.
- R10: In a cycle where `out_valid` is low, `wr_mem`, `wr_ac`, `take`, `flag_upd` and the three flags are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_class | input | 3 | Instruction class, encoded as in R3 to R9 |
| cond | input | 3 | Condition code, encoded as in R2 |
| ac_sel | input | 4 | Accumulator field of the instruction |
| ac_val | input | 36 | Current accumulator value |
| operand | input | 36 | Immediate effective address or memory word |
| out_valid | output | 1 | Outputs hold a finished operation |
| result | output | 36 | Value to store |
| wr_mem | output | 1 | Store `result` to the memory word |
| wr_ac | output | 1 | Store `result` to the accumulator |
| take | output | 1 | Skip or jump is taken |
| flag_upd | output | 1 | Arithmetic flags are to be updated |
| carry0 | output | 1 | Carry out of the most significant bit |
| carry1 | output | 1 | Carry into the most significant bit |
| ovf | output | 1 | Signed overflow of the +1/-1 |

## Verification
The overflow flag and the skip or jump decision can both be raised by the same operation, and the decision must use the wrapped value rather than the mathematically true one. This case is provoked by incrementing 36'h7FFFFFFFF under code 1 and decrementing 36'h800000000 under code 5. The bench then expects `ovf`, the carries and `take` together in the same output cycle. The half-word form is also pushed across the 18-bit boundary, to confirm that a carry out of the right half never appears in the left half or in the flags.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [2:0] {
    CLS_CMP      = 3'd0,
    CLS_MTEST    = 3'd1,
    CLS_INC_SKIP = 3'd2,
    CLS_DEC_SKIP = 3'd3,
    CLS_INC_JMP  = 3'd4,
    CLS_DEC_JMP  = 3'd5,
    CLS_HALF_JMP = 3'd6,
    CLS_RSVD     = 3'd7
  } cls_e;

  // Shared condition table: lt and eq describe the signed relation x ? y.
  function automatic logic cond_hit(input logic [2:0] code, input logic lt, input logic eq);
    case (code)
      3'd0:    cond_hit = 1'b0;
      3'd1:    cond_hit = lt;
      3'd2:    cond_hit = eq;
      3'd3:    cond_hit = lt | eq;
      3'd4:    cond_hit = 1'b1;
      3'd5:    cond_hit = ~lt;
      3'd6:    cond_hit = ~eq;
      default: cond_hit = ~(lt | eq);
    endcase
  endfunction

endpackage

// File: rtl/cs_step_adder.sv
module cs_step_adder #(
  parameter int W = 36
) (
  input  logic [W-1:0] a,
  input  logic         dec,
  input  logic         half,
  output logic [W-1:0] sum,
  output logic         c_msb_out,
  output logic         c_msb_in,
  output logic         wrap
);
  localparam int H  = W / 2;
  localparam int HL = W - H;

  logic [W-1:0] addend;
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic [H-1:0]  right_inc;
  logic [HL-1:0] left_inc;

  assign addend    = dec ? {W{1'b1}} : W'(1);
  assign full_sum  = {1'b0, a} + {1'b0, addend};
  assign low_sum   = {1'b0, a[W-2:0]} + {1'b0, addend[W-2:0]};

  // Half form: each half incremented on its own, no carry across the boundary.
  assign right_inc = a[H-1:0] + H'(1);
  assign left_inc  = a[W-1:H] + HL'(1);

  always_comb begin
    if (half) begin
      sum       = {left_inc, right_inc};
      c_msb_out = 1'b0;
      c_msb_in  = 1'b0;
    end else begin
      sum       = full_sum[W-1:0];
      c_msb_out = full_sum[W];
      c_msb_in  = low_sum[W-1];
    end
    wrap = c_msb_out ^ c_msb_in;
  end

endmodule

// File: rtl/cs_cond_eval.sv
module cs_cond_eval #(
  parameter int W = 36
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [2:0]   code,
  output logic         hit
);
  import cs_pkg::*;

  logic rel_lt;
  logic rel_eq;

  assign rel_lt = $signed(x) < $signed(y);
  assign rel_eq = (x == y);
  assign hit    = cond_hit(code, rel_lt, rel_eq);

endmodule

// File: rtl/cs_cond_unit.sv
module cs_cond_unit #(
  parameter int W    = 36,
  parameter int AC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op_class,
  input  logic [2:0]      cond,
  input  logic [AC_W-1:0] ac_sel,
  input  logic [W-1:0]    ac_val,
  input  logic [W-1:0]    operand,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            wr_mem,
  output logic            wr_ac,
  output logic            take,
  output logic            flag_upd,
  output logic            carry0,
  output logic            carry1,
  output logic            ovf
);
  import cs_pkg::*;

  cls_e cls;
  assign cls = cls_e'(op_class);

  // Named decode events
  logic ac_field_nz;
  logic step_from_mem;
  logic step_dec;
  logic step_half;
  logic step_used;

  assign ac_field_nz   = (ac_sel != '0);
  assign step_from_mem = (cls == CLS_INC_SKIP) || (cls == CLS_DEC_SKIP);
  assign step_dec      = (cls == CLS_DEC_SKIP) || (cls == CLS_DEC_JMP);
  assign step_half     = (cls == CLS_HALF_JMP);
  assign step_used     = step_from_mem || (cls == CLS_INC_JMP) || (cls == CLS_DEC_JMP);

  logic [W-1:0] step_src;
  logic [W-1:0] step_sum;
  logic         st_c0, st_c1, st_wrap;

  assign step_src = step_from_mem ? operand : ac_val;

  cs_step_adder #(.W(W)) u_step (
    .a         (step_src),
    .dec       (step_dec),
    .half      (step_half),
    .sum       (step_sum),
    .c_msb_out (st_c0),
    .c_msb_in  (st_c1),
    .wrap      (st_wrap)
  );

  logic [W-1:0] ev_x, ev_y;
  logic         ev_hit;

  always_comb begin
    case (cls)
      CLS_CMP:   begin ev_x = ac_val;   ev_y = operand; end
      CLS_MTEST: begin ev_x = operand;  ev_y = '0;      end
      default:   begin ev_x = step_sum; ev_y = '0;      end
    endcase
  end

  cs_cond_eval #(.W(W)) u_eval (
    .x    (ev_x),
    .y    (ev_y),
    .code (cond),
    .hit  (ev_hit)
  );

  logic [W-1:0] nx_result;
  logic         nx_wr_mem, nx_wr_ac, nx_take, nx_flag;

  always_comb begin
    nx_result = '0;
    nx_wr_mem = 1'b0;
    nx_wr_ac  = 1'b0;
    nx_take   = 1'b0;
    nx_flag   = 1'b0;
    case (cls)
      CLS_CMP: begin
        nx_result = ac_val;
        nx_take   = ev_hit;
      end
      CLS_MTEST: begin
        nx_result = operand;
        nx_wr_ac  = ac_field_nz;
        nx_take   = ev_hit;
      end
      CLS_INC_SKIP, CLS_DEC_SKIP: begin
        nx_result = step_sum;
        nx_wr_mem = 1'b1;
        nx_wr_ac  = ac_field_nz;
        nx_take   = ev_hit;
        nx_flag   = 1'b1;
      end
      CLS_INC_JMP, CLS_DEC_JMP, CLS_HALF_JMP: begin
        nx_result = step_sum;
        nx_wr_ac  = 1'b1;
        nx_take   = ev_hit;
        nx_flag   = step_used;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_mem    <= 1'b0;
      wr_ac     <= 1'b0;
      take      <= 1'b0;
      flag_upd  <= 1'b0;
      carry0    <= 1'b0;
      carry1    <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result    <= in_valid ? nx_result : '0;
      wr_mem    <= in_valid & nx_wr_mem;
      wr_ac     <= in_valid & nx_wr_ac;
      take      <= in_valid & nx_take;
      flag_upd  <= in_valid & nx_flag;
      carry0    <= in_valid & nx_flag & st_c0;
      carry1    <= in_valid & nx_flag & st_c1;
      ovf       <= in_valid & nx_flag & st_wrap;
    end
  end

endmodule

// File: rtl/cs_cond_unit_chk.sv
module cs_cond_unit_chk #(
  parameter int W    = 36,
  parameter int AC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      op_class,
  input logic [2:0]      cond,
  input logic [AC_W-1:0] ac_sel,
  input logic [W-1:0]    ac_val,
  input logic [W-1:0]    operand,
  input logic            out_valid,
  input logic [W-1:0]    result,
  input logic            wr_mem,
  input logic            wr_ac,
  input logic            take,
  input logic            flag_upd,
  input logic            carry0,
  input logic            carry1,
  input logic            ovf
);
  localparam int H = W / 2;

  logic mem_class_zero_ac;
  assign mem_class_zero_ac = in_valid && (op_class >= 3'd1) && (op_class <= 3'd3) && (ac_sel == '0);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_latency_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_never_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd0) |=> !take);
  assert_always_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd4 && op_class != 3'd7) |=> take);
  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == 3'd0) |=> (!wr_ac && !wr_mem && !flag_upd && result == $past(ac_val)));
  assert_ac_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_class_zero_ac |=> !wr_ac);
  assert_mem_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_class == 3'd2 || op_class == 3'd3)) |=> (wr_mem && flag_upd));
  assert_jump_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class >= 3'd4 && op_class <= 3'd6) |=> (wr_ac && !wr_mem));
  assert_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == 3'd6) |=> (!flag_upd && result[H-1:0] == $past(operand[H-1:0] & '0) + $past(ac_val[H-1:0]) + H'(1)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (flag_upd && (carry0 != carry1)));
  assert_flags_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |-> !(carry0 || carry1 || ovf));
  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_class == 3'd7) |=> !(wr_ac || wr_mem || take || flag_upd));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(wr_mem || wr_ac || take || flag_upd || result != '0));

endmodule

bind cs_cond_unit cs_cond_unit_chk #(.W(W), .AC_W(AC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class), .cond(cond),
  .ac_sel(ac_sel), .ac_val(ac_val), .operand(operand), .out_valid(out_valid),
  .result(result), .wr_mem(wr_mem), .wr_ac(wr_ac), .take(take), .flag_upd(flag_upd),
  .carry0(carry0), .carry1(carry1), .ovf(ovf)
);

// File: tb/tb_cs_cond_unit.sv
`timescale 1ns/100ps
module tb_cs_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_class = '0;
  logic [2:0]  cond = '0;
  logic [3:0]  ac_sel = '0;
  logic [35:0] ac_val = '0;
  logic [35:0] operand = '0;
  logic        out_valid, wr_mem, wr_ac, take, flag_upd, carry0, carry1, ovf;
  logic [35:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cs_cond_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class), .cond(cond),
    .ac_sel(ac_sel), .ac_val(ac_val), .operand(operand), .out_valid(out_valid),
    .result(result), .wr_mem(wr_mem), .wr_ac(wr_ac), .take(take), .flag_upd(flag_upd),
    .carry0(carry0), .carry1(carry1), .ovf(ovf)
  );

  // stimulus: class(3) cond(3) ac_sel(4) ac(36) operand(36)
  localparam int NV = 18;
  localparam logic [81:0] VEC [NV] = '{
    {3'd0, 3'd1, 4'd1, 36'hFFFFFFFFF, 36'h000000001},
    {3'd0, 3'd7, 4'd1, 36'h000000005, 36'h000000003},
    {3'd0, 3'd2, 4'd0, 36'h123456789, 36'h123456789},
    {3'd0, 3'd0, 4'd2, 36'h000000001, 36'h000000009},
    {3'd1, 3'd6, 4'd0, 36'h000000000, 36'h000000400},
    {3'd1, 3'd3, 4'd7, 36'h000000000, 36'h800000000},
    {3'd2, 3'd2, 4'd1, 36'h000000000, 36'hFFFFFFFFF},
    {3'd2, 3'd0, 4'd0, 36'h000000000, 36'h7FFFFFFFF},
    {3'd3, 3'd5, 4'd4, 36'h000000000, 36'h000000000},
    {3'd3, 3'd6, 4'd0, 36'h000000000, 36'h000000001},
    {3'd4, 3'd7, 4'd0, 36'h000000041, 36'h000000000},
    {3'd4, 3'd4, 4'd3, 36'hFFFFFFFFE, 36'h000000000},
    {3'd5, 3'd3, 4'd1, 36'h000000001, 36'h000000000},
    {3'd5, 3'd1, 4'd1, 36'h000000000, 36'h0000000AA},
    {3'd6, 3'd5, 4'd1, 36'h00003FFFF, 36'h000000000},
    {3'd6, 3'd1, 4'd1, 36'hFFFFC0005, 36'h000000000},
    {3'd7, 3'd4, 4'd1, 36'h000000011, 36'h000000022},
    {3'd7, 3'd6, 4'd0, 36'h7FFFFFFFF, 36'h000000000}
  };

  // Reference: {result, wr_mem, wr_ac, take, flag_upd, carry0, carry1, ovf}
  function automatic logic [42:0] model(input logic [2:0] c, input logic [2:0] cd,
                                        input logic [3:0] sel, input logic [35:0] a, input logic [35:0] m);
    logic [35:0] r, src, inc;
    logic wm, wa, tk, fu, c0, c1, ov, neg, zero;
    logic [36:0] wide;
    logic [35:0] part;
    r = '0; wm = 0; wa = 0; tk = 0; fu = 0; c0 = 0; c1 = 0; ov = 0;
    neg = 0; zero = 0;
    src = (c == 3'd2 || c == 3'd3) ? m : a;
    inc = (c == 3'd3 || c == 3'd5) ? 36'hFFFFFFFFF : 36'h000000001;
    if (c >= 3'd2 && c <= 3'd5) begin
      wide = {1'b0, src} + {1'b0, inc};
      part = {1'b0, src[34:0]} + {1'b0, inc[34:0]};
      r  = wide[35:0];
      c0 = wide[36];
      c1 = part[35];
      ov = (src[35] == inc[35]) && (r[35] != src[35]);
      fu = 1;
    end
    case (c)
      3'd0: begin r = a; neg = $signed(a) < $signed(m); zero = (a == m); end
      3'd1: begin r = m; wa = (sel != 0); end
      3'd2, 3'd3: begin wm = 1; wa = (sel != 0); end
      3'd4, 3'd5: wa = 1;
      3'd6: begin r = {a[35:18] + 18'd1, a[17:0] + 18'd1}; wa = 1; end
      default: ;
    endcase
    if (c != 3'd0) begin neg = r[35]; zero = (r == 0); end
    case (cd)
      3'd0: tk = 0;
      3'd1: tk = neg;
      3'd2: tk = zero;
      3'd3: tk = neg || zero;
      3'd4: tk = 1;
      3'd5: tk = !neg;
      3'd6: tk = !zero;
      default: tk = !neg && !zero;
    endcase
    if (c == 3'd7) begin r = '0; tk = 0; end
    return {r, wm, wa, tk, fu, c0, c1, ov};
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [2:0] cd, input logic [3:0] sel,
                       input logic [35:0] a, input logic [35:0] m);
    @(negedge clk);
    op_class = c; cond = cd; ac_sel = sel; ac_val = a; operand = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [35:0] ctl();
    return {28'd0, out_valid, wr_mem, wr_ac, take, flag_upd, carry0, carry1, ovf};
  endfunction

  initial begin
    logic [42:0] e;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "reset result", result, 36'h0);
    chk("R1", "reset controls", ctl(), 36'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][81:79], VEC[i][78:76], VEC[i][75:72], VEC[i][71:36], VEC[i][35:0]);
      e = model(VEC[i][81:79], VEC[i][78:76], VEC[i][75:72], VEC[i][71:36], VEC[i][35:0]);
      chk(req_of(VEC[i][81:79]), "vector result", result, e[42:7]);
      chk(req_of(VEC[i][81:79]), "vector controls (R2 R8)", ctl(), {28'd0, 1'b1, e[6:0]});
    end

    // R8 with R5: increment of largest positive wraps, code 1 sees the wrapped negative value
    issue(3'd2, 3'd1, 4'd3, 36'h0, 36'h7FFFFFFFF);
    chk("R8", "inc wrap result", result, 36'h800000000);
    chk("R8", "inc wrap ctl", ctl(), {28'd0, 8'b1111_1011});

    // R8 with R6: decrement of most negative wraps, code 5 takes
    issue(3'd5, 3'd5, 4'd0, 36'h800000000, 36'h0);
    chk("R8", "dec wrap result", result, 36'h7FFFFFFFF);
    chk("R8", "dec wrap ctl", ctl(), {28'd0, 8'b1011_1101});

    // R7: both halves wrap to zero, no carry across, code 5 jumps, no flags
    issue(3'd6, 3'd5, 4'd1, 36'hFFFFFFFFF, 36'h0);
    chk("R7", "half all-ones", result, 36'h000000000);
    chk("R7", "half ctl", ctl(), {28'd0, 8'b1011_0000});

    // R7: right half carry blocked, code 1 on nonnegative result does not jump
    issue(3'd6, 3'd1, 4'd1, 36'h00017FFFF, 36'h0);
    chk("R7", "half blocked carry", result, 36'h000180000);
    chk("R7", "half no jump", ctl(), {28'd0, 8'b1010_0000});

    // R3: signed compare, -1 < 1
    issue(3'd0, 3'd1, 4'd5, 36'hFFFFFFFFF, 36'h000000001);
    chk("R3", "signed lt takes", ctl(), {28'd0, 8'b1001_0000});

    // R4: memory test with zero AC field does not write AC
    issue(3'd1, 3'd4, 4'd0, 36'h0, 36'h555555555);
    chk("R4", "zero ac field", ctl(), {28'd0, 8'b1001_0000});

    // R2: code 0 never skips even on a zero result
    issue(3'd3, 3'd0, 4'd2, 36'h0, 36'h000000001);
    chk("R2", "code 0 no skip", take, 36'h0);

    // R9: reserved class
    issue(3'd7, 3'd4, 4'd1, 36'h1, 36'h2);
    chk("R9", "reserved ctl", ctl(), {28'd0, 8'b1000_0000});

    // R10: idle cycle after an operation
    @(negedge clk);
    chk("R10", "idle ctl", ctl(), 36'h0);
    chk("R10", "idle result", result, 36'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule